// File: doc/BRIEF.md
# Cartridge ROM Bus Address Mapper

This block sits between a console's 24-bit system bus and a cartridge ROM. The bus address is an 8-bit bank and a 16-bit offset. The block decides whether an access falls inside a ROM window. If it does, it raises a ROM select strobe and forms the ROM byte address. The ROM read port is synchronous: it captures the address at a clock edge, and the block returns the byte to the bus one clock after the request.

The whole mapping comes down to two settings. The first is the set of bus regions where ROM is visible. The second is whether offset bit 15 is kept in the ROM address or removed from it.

- Mode 0 (squeeze) drops bit 15 and moves the bank bits down one place. Each bank then holds 32 KiB of ROM.
- Mode 1 (keep) passes bit 15 through. Each bank then holds a full 64 KiB.

Two static inputs suppress parts of the upper bank half, because some boards leave those areas empty. The ROM address is cut to the configured ROM width. A smaller ROM therefore repeats across its window.

Top module: `cart_rom_mapper`

## Requirements
- R1: After reset, and until the first request, bus_valid is 0 and bus_rdata is 8'hFF.
- R2: With bus_req high, rom_cs is high exactly when bank bit 6 or offset bit 15 is 1, unless R9 or R10 suppresses the access.
- R3: When cfg_mode is 0, rom_addr is the low ROM_AW bits of {bank[6:0], offset[14:0]}.
- R4: When cfg_mode is 0, bus C0:0000, bus C0:8000 and bus 40:8000 all read the same ROM byte. When the ROM is 2 MiB or smaller, bus 00:8000 also reads that byte.
- R5: When cfg_mode is 1, rom_addr is the low ROM_AW bits of {bank[5:0], offset[15:0]}.
- R6: When cfg_mode is 1, a secondary window access at bank b (bit 6 = 0), offset 8000-FFFF, reads the same byte as bank b|0x40 at the same offset. For example, bus 01:8000 reads ROM 018000.
- R7: Bank bit 7 has no effect on rom_addr or read data. Banks 80-FF mirror banks 00-7F unless R9 or R10 applies.
- R8: A ROM address bit at position ROM_AW or above never reaches rom_addr. Addresses that differ only in such bits read the same byte.
- R9: When cfg_drop_upper_low is 1, accesses to banks C0-FF at offsets 0000-7FFF do not assert rom_cs.
- R10: When cfg_drop_upper_bank is 1, no access to banks 80-FF asserts rom_cs.
- R11: When a request is not selected, the next cycle returns bus_rdata = 8'hFF.
- R12: rom_cs and rom_addr follow the bus address in the same cycle. In the cycle after a request, bus_valid is 1 and bus_rdata carries the ROM byte of a selected access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 0: drop offset bit 15; 1: keep it |
| cfg_drop_upper_low | input | 1 | Suppress ROM in banks C0-FF, offsets 0000-7FFF |
| cfg_drop_upper_bank | input | 1 | Suppress ROM in banks 80-FF |
| bus_req | input | 1 | Read request this cycle |
| bus_addr | input | 24 | Bank (23:16) and offset (15:0) |
| bus_valid | output | 1 | Read data valid (one cycle after bus_req) |
| bus_rdata | output | 8 | Read data, or 8'hFF when not selected |
| rom_cs | output | 1 | ROM read enable |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_rdata | input | 8 | ROM data, one cycle after rom_cs |

## Verification
The only state in this block is the registered hit flag and the valid bit, so a wrong internal state shows on bus_rdata in the cycle after the request. A stale hit flag returns a ROM byte where 8'hFF is expected, or 8'hFF where a ROM byte is expected. Decode and address errors show in the same cycle on rom_cs and rom_addr. They are also visible one cycle later as a data mismatch, because the bench's ROM holds a distinct function of the address. The bench sweeps every bank, a set of offsets on both sides of bit 15, both modes and all suppression settings. It also compares each mirror against its linear location.

// File: rtl/rom_map_pkg.sv
package rom_map_pkg;

    localparam int BUS_AW      = 24;
    localparam int FULL_ROM_AW = 22;
    localparam logic [7:0] OPEN_BUS = 8'hFF;

    typedef enum logic {
        MAP_SQUEEZE = 1'b0,
        MAP_KEEP    = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic [7:0]  bank;
        logic [15:0] offset;
    } bus_addr_t;

    // Mode 0: offset bit 15 removed, bank bits 6:0 move down one place
    function automatic logic [FULL_ROM_AW-1:0] squeeze_addr(input logic [22:0] a);
        return {a[22:16], a[14:0]};
    endfunction

    // Mode 1: linear, offset bit 15 kept
    function automatic logic [FULL_ROM_AW-1:0] keep_addr(input logic [21:0] a);
        return a;
    endfunction

endpackage

// File: rtl/cart_rom_region_dec.sv
module cart_rom_region_dec
    import rom_map_pkg::*;
(
    input  logic [7:0] bank,
    input  logic       off_hi,
    input  logic       drop_upper_low,
    input  logic       drop_upper_bank,
    output logic       hit
);
    logic in_window;
    logic upper_low_area;
    logic suppressed;

    always_comb begin
        // Linear banks (bit 6 set) decode any offset; the others only the upper half
        in_window      = bank[6] | off_hi;
        upper_low_area = bank[7] & bank[6] & ~off_hi;
        suppressed     = (drop_upper_bank & bank[7]) |
                         (drop_upper_low & upper_low_area);
        hit            = in_window & ~suppressed;
    end
endmodule

// File: rtl/cart_rom_addr_xlate.sv
module cart_rom_addr_xlate
    import rom_map_pkg::*;
#(
    parameter int ROM_AW = 22
) (
    input  map_mode_e         mode,
    input  logic [22:0]       addr_in,
    output logic [ROM_AW-1:0] rom_addr
);
    always_comb begin
        unique case (mode)
            MAP_SQUEEZE: rom_addr = ROM_AW'(squeeze_addr(addr_in));
            MAP_KEEP:    rom_addr = ROM_AW'(keep_addr(addr_in[21:0]));
            default:     rom_addr = '0;
        endcase
    end
endmodule

// File: rtl/cart_rom_rd_stage.sv
module cart_rom_rd_stage
    import rom_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       hit,
    input  logic [7:0] rom_rdata,
    output logic       valid,
    output logic [7:0] rdata
);
    logic hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            valid <= req;
            hit_q <= req & hit;
        end
    end

    assign rdata = hit_q ? rom_rdata : OPEN_BUS;
endmodule

// File: rtl/cart_rom_mapper.sv
module cart_rom_mapper
    import rom_map_pkg::*;
#(
    parameter int ROM_AW = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic              cfg_drop_upper_low,
    input  logic              cfg_drop_upper_bank,
    input  logic              bus_req,
    input  logic [23:0]       bus_addr,
    output logic              bus_valid,
    output logic [7:0]        bus_rdata,
    output logic              rom_cs,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_rdata
);
    localparam int MIN_AW = 16;

    initial begin
        if (ROM_AW < MIN_AW || ROM_AW > FULL_ROM_AW)
            $error("ROM_AW out of range");
    end

    bus_addr_t ba;
    logic      region_hit;
    map_mode_e mode;

    assign ba   = bus_addr;
    assign mode = map_mode_e'(cfg_mode);

    cart_rom_region_dec u_region (
        .bank            (ba.bank),
        .off_hi          (ba.offset[15]),
        .drop_upper_low  (cfg_drop_upper_low),
        .drop_upper_bank (cfg_drop_upper_bank),
        .hit             (region_hit)
    );

    cart_rom_addr_xlate #(.ROM_AW(ROM_AW)) u_xlate (
        .mode     (mode),
        .addr_in  ({ba.bank[6:0], ba.offset}),
        .rom_addr (rom_addr)
    );

    assign rom_cs = bus_req & region_hit;

    cart_rom_rd_stage u_rd (
        .clk       (clk),
        .rst       (rst),
        .req       (bus_req),
        .hit       (region_hit),
        .rom_rdata (rom_rdata),
        .valid     (bus_valid),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/cart_rom_mapper_chk.sv
module cart_rom_mapper_chk #(
    parameter int ROM_AW = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_mode,
    input logic              cfg_drop_upper_low,
    input logic              cfg_drop_upper_bank,
    input logic              bus_req,
    input logic [23:0]       bus_addr,
    input logic              bus_valid,
    input logic [7:0]        bus_rdata,
    input logic              rom_cs,
    input logic [ROM_AW-1:0] rom_addr
);
    a_r2_outside_no_cs: assert property (@(posedge clk) disable iff (rst)
        (!bus_addr[22] && !bus_addr[15]) |-> !rom_cs);

    a_r2_cs_needs_req: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> bus_req);

    a_r10_upper_bank_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_drop_upper_bank && bus_addr[23]) |-> !rom_cs);

    a_r9_upper_low_off: assert property (@(posedge clk) disable iff (rst)
        (cfg_drop_upper_low && bus_addr[23] && bus_addr[22] && !bus_addr[15]) |-> !rom_cs);

    a_r3_r5_low_bits: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> (rom_addr[14:0] == bus_addr[14:0]));

    a_r5_keep_bit15: assert property (@(posedge clk) disable iff (rst)
        (rom_cs && cfg_mode) |-> (rom_addr[15] == bus_addr[15]));

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        bus_req |=> bus_valid);

    a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_valid);

    a_r11_open_bus: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !rom_cs) |=> (bus_rdata == 8'hFF));
endmodule

bind cart_rom_mapper cart_rom_mapper_chk #(.ROM_AW(ROM_AW)) u_chk (
    .clk                 (clk),
    .rst                 (rst),
    .cfg_mode            (cfg_mode),
    .cfg_drop_upper_low  (cfg_drop_upper_low),
    .cfg_drop_upper_bank (cfg_drop_upper_bank),
    .bus_req             (bus_req),
    .bus_addr            (bus_addr),
    .bus_valid           (bus_valid),
    .bus_rdata           (bus_rdata),
    .rom_cs              (rom_cs),
    .rom_addr            (rom_addr)
);

// File: tb/cart_rom_mapper_tb.sv
module cart_rom_mapper_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_mode = 1'b0;
    logic          cfg_drop_upper_low = 1'b0;
    logic          cfg_drop_upper_bank = 1'b0;
    logic          bus_req = 1'b0;
    logic [23:0]   bus_addr = '0;
    logic          bus_valid;
    logic [7:0]    bus_rdata;
    logic          rom_cs;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_q = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cart_rom_mapper #(.ROM_AW(AW)) u_dut (
        .clk                 (clk),
        .rst                 (rst),
        .cfg_mode            (cfg_mode),
        .cfg_drop_upper_low  (cfg_drop_upper_low),
        .cfg_drop_upper_bank (cfg_drop_upper_bank),
        .bus_req             (bus_req),
        .bus_addr            (bus_addr),
        .bus_valid           (bus_valid),
        .bus_rdata           (bus_rdata),
        .rom_cs              (rom_cs),
        .rom_addr            (rom_addr),
        .rom_rdata           (rom_q)
    );

    function automatic logic [7:0] rom_fn(input logic [AW-1:0] a);
        logic [23:0] w;
        w = 24'(a);
        return w[7:0] ^ {w[14:8], w[15]} ^ {w[19:16], w[19:16]} ^ 8'h3C;
    endfunction

    // Synchronous ROM model
    always @(posedge clk) if (rom_cs) rom_q <= rom_fn(rom_addr);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(input logic [23:0] a);
        logic [7:0] b;
        b = a[23:16];
        if (cfg_drop_upper_bank && b[7]) return 1'b0;
        if (cfg_drop_upper_low && b[7] && b[6] && !a[15]) return 1'b0;
        return b[6] | a[15];
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [23:0] a);
        logic [21:0] full;
        if (cfg_mode) full = a[21:0];
        else          full = {a[22:16], a[14:0]};
        return full[AW-1:0];
    endfunction

    // One request, then one idle cycle; returns the observed values
    task automatic access(input logic [23:0] a, output bit cs, output logic [AW-1:0] ra,
                          output logic [7:0] rd, output bit vld);
        @(negedge clk);
        bus_addr = a;
        bus_req  = 1'b1;
        #1;
        cs = rom_cs;
        ra = rom_addr;
        @(negedge clk);
        bus_req = 1'b0;
        #1;
        rd  = bus_rdata;
        vld = bus_valid;
    endtask

    task automatic sweep_one(input logic [23:0] a);
        bit cs, vld, eh;
        logic [AW-1:0] ra, ea;
        logic [7:0] rd, ed;
        string rtag;
        access(a, cs, ra, rd, vld);
        eh = exp_hit(a);
        ea = exp_addr(a);
        if (cfg_drop_upper_bank && a[23]) rtag = "R10";
        else if (cfg_drop_upper_low && a[23] && a[22] && !a[15]) rtag = "R9";
        else rtag = "R2";
        check(cs == eh, rtag, 32'(cs), 32'(eh));
        if (eh) check(ra == ea, cfg_mode ? "R5" : "R3", 32'(ra), 32'(ea));
        check(vld == 1'b1, "R12", 32'(vld), 32'd1);
        ed = eh ? rom_fn(ea) : 8'hFF;
        check(rd == ed, eh ? "R12" : "R11", 32'(rd), 32'(ed));
    endtask

    task automatic same_byte(input logic [23:0] a0, input logic [23:0] a1, input string tag);
        bit c0, c1, v0, v1;
        logic [AW-1:0] r0, r1;
        logic [7:0] d0, d1;
        access(a0, c0, r0, d0, v0);
        access(a1, c1, r1, d1, v1);
        check(c0 && c1, tag, {30'd0, c0, c1}, 32'd3);
        check(r0 == r1, tag, 32'(r1), 32'(r0));
        check(d0 == d1, tag, 32'(d1), 32'(d0));
    endtask

    initial begin
        logic [15:0] offs [6];
        offs = '{16'h0000, 16'h1234, 16'h7FFF, 16'h8000, 16'hABCD, 16'hFFFF};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check(bus_valid == 1'b0, "R1", 32'(bus_valid), 32'd0);
        check(bus_rdata == 8'hFF, "R1", 32'(bus_rdata), 32'hFF);

        // Mirror checks
        cfg_mode = 1'b0;
        same_byte(24'hC00000, 24'hC08000, "R4");
        same_byte(24'hC00000, 24'h408000, "R4");
        same_byte(24'hC00000, 24'h008000, "R4");
        same_byte(24'h059000, 24'h859000, "R7");
        cfg_mode = 1'b1;
        same_byte(24'h018000, 24'h418000, "R6");
        same_byte(24'h3FFFFF, 24'h7FFFFF, "R6");
        same_byte(24'h059000, 24'h859000, "R7");
        same_byte(24'h401234, 24'h501234, "R8");
        cfg_mode = 1'b0;
        same_byte(24'h40ABCD, 24'h60ABCD, "R8");

        // Full sweep over modes, suppression settings, banks and offsets
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 4; f++) begin
                cfg_mode            = m[0];
                cfg_drop_upper_low  = f[0];
                cfg_drop_upper_bank = f[1];
                for (int b = 0; b < 256; b++) begin
                    for (int o = 0; o < 6; o++) begin
                        sweep_one({b[7:0], offs[o]});
                    end
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule